// File: doc/BRIEF.md
# Extended Mode Register Capture and Decode

This block sits on the device side of a low-power DDR command bus and watches for writes to the extended mode register. When a legal extended-mode write is seen, it stores two 3-bit fields taken from the address bus. The first is the partial-array self-refresh selection and the second is the output drive-strength selection. It also presents both fields in decoded form: the refreshed area in quarters of the array, and the drive strength in eighths of full strength.

The block enforces the usage rules for this command. A write is accepted only if:
- every bank is idle,
- clock enable has been high for this cycle and the one before,
- the address bits outside the two fields are zero,
- the refresh selection is not a reserved code, and
- no earlier extended-mode write is still completing.

A rejected command leaves the stored fields untouched. It raises a one-cycle error pulse that names the broken rule. An accepted write holds a busy flag for two cycles. Any command issued in that window is reported as a collision.

Top module: `ext_mode_reg`

## Requirements
- R1: A cycle with csN, rasN, casN and weN all low and bankAddr equal to 2'b10 is an extended-mode write. When it is accepted, refreshCode takes addr[2:0] and driveCode takes addr[7:5], and both are visible after that clock edge. A command with any other bankAddr value leaves both fields unchanged.
- R2: An extended-mode write issued while any bit of bankIdle is 0 is rejected. errIllegal is high for the one cycle after that edge, and both fields keep their values.
- R3: An extended-mode write is rejected, with errIllegal pulsed for one cycle, unless cke is high in both the command cycle and the cycle before it. This includes the first cycle after reset.
- R4: An extended-mode write with any of addr[13:8], addr[4] or addr[3] high is rejected, and errReserved is pulsed for one cycle.
- R5: After an accepted write, busy is high for exactly two cycles and then returns low.
- R6: Any command issued while busy is high sets errCollide for one cycle. A command here means csN low and not all of rasN, casN and weN high. An extended-mode write issued in this state is rejected.
- R7: An extended-mode write with addr[2:0] in the range 3 to 7 is rejected, and errRefCode is pulsed for one cycle.
- R8: areaQuarters is 4 for refresh code 0, 2 for code 1 and 1 for code 2.
- R9: driveEighths gives the drive-strength numerator over 8. Codes 0 to 7 map to 8, 4, 2, 1, 6, 3, 5 and 7 in that order.
- R10: Read and write commands issued before an extended-mode write do not stop it from being accepted, provided all banks are idle when it is issued.
- R11: After reset, both codes are 0, areaQuarters is 4, driveEighths is 8, and busy and all error flags are low.
- R12: A cycle with csN high changes nothing and raises no flag, whatever the other command pins hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| bankAddr | input | 2 | Bank address bits |
| addr | input | 14 | Address bus |
| bankIdle | input | 4 | Per-bank idle status, 1 means precharged |
| refreshCode | output | 3 | Stored self-refresh area code |
| driveCode | output | 3 | Stored drive-strength code |
| areaQuarters | output | 3 | Refreshed area in quarters of the array |
| driveEighths | output | 4 | Drive strength in eighths of full |
| busy | output | 1 | Register write in progress |
| errIllegal | output | 1 | Idle or clock-enable rule broken |
| errReserved | output | 1 | Reserved address bit set |
| errRefCode | output | 1 | Reserved refresh code requested |
| errCollide | output | 1 | Command issued while busy |

## Verification
The main function is exercised first with a sweep of legal writes that covers all eight drive codes and all three legal refresh codes. This shows that the two fields come from the right address bits and that each one decodes correctly. Each rule is then tested with a write that breaks only that rule: a non-idle bank, clock enable only just raised, a single reserved bit set, or a reserved refresh code. This shows that each error flag is tied to its own cause.

Two further groups of commands are placed around accepted writes. Back-to-back commands and reads issued inside the busy window separate collision handling from ordinary rejection. Reads and writes issued before a write, along with cycles with chip select high or a different bank address, show that unrelated traffic neither blocks a write nor changes the stored fields.

// File: rtl/ext_mode_pkg.sv
package ext_mode_pkg;
  parameter int ADDR_W     = 14;
  parameter int NUM_BANKS  = 4;
  parameter int CODE_W     = 3;
  parameter int WRITE_CYC  = 2;
  localparam int CNT_W     = $clog2(WRITE_CYC + 1);
  localparam logic [1:0] EXT_BANK_SEL = 2'b10;
  localparam logic [CODE_W-1:0] MAX_REF_CODE = 3'd2;

  typedef struct packed {
    logic capture;
    logic illegal;
    logic reservedBits;
    logic badRefresh;
    logic collide;
  } emr_strobes_t;
endpackage

// File: rtl/emr_ctrl.sv
module emr_ctrl
  import ext_mode_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic                 cke,
  input  logic [1:0]           bankAddr,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_BANKS-1:0] bankIdle,
  output emr_strobes_t         strobes,
  output logic                 busy
);
  logic             ckePrev;
  logic [CNT_W-1:0] busyCnt;
  logic             cmdActive, isExtWrite, rsvHit, badRef, precondOk;

  always_comb begin
    cmdActive  = !csN && !(rasN && casN && weN);
    isExtWrite = !csN && !rasN && !casN && !weN && (bankAddr == EXT_BANK_SEL);
    rsvHit     = |{addr[ADDR_W-1:8], addr[4:3]};
    badRef     = addr[CODE_W-1:0] > MAX_REF_CODE;
    precondOk  = (&bankIdle) && cke && ckePrev;
    strobes.collide      = cmdActive && busy;
    strobes.illegal      = isExtWrite && !precondOk;
    strobes.reservedBits = isExtWrite && rsvHit;
    strobes.badRefresh   = isExtWrite && badRef;
    strobes.capture      = isExtWrite && !busy && precondOk && !rsvHit && !badRef;
  end

  assign busy = (busyCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ckePrev <= 1'b0;
      busyCnt <= '0;
    end else begin
      ckePrev <= cke;
      if (strobes.capture)  busyCnt <= CNT_W'(WRITE_CYC);
      else if (busy)        busyCnt <= busyCnt - 1'b1;
    end
  end

  a_r5_busy_after_capture: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> busy);
  a_r3_cke_needs_history: assert property (@(posedge clk) disable iff (!rstN)
    (isExtWrite && !$past(cke)) |-> !strobes.capture);
endmodule

// File: rtl/emr_datapath.sv
module emr_datapath
  import ext_mode_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  emr_strobes_t        strobes,
  input  logic [ADDR_W-1:0]   addr,
  output logic [CODE_W-1:0]   refreshCode,
  output logic [CODE_W-1:0]   driveCode,
  output logic [2:0]          areaQuarters,
  output logic [3:0]          driveEighths,
  output logic                errIllegal,
  output logic                errReserved,
  output logic                errRefCode,
  output logic                errCollide
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refreshCode <= '0;
      driveCode   <= '0;
      errIllegal  <= 1'b0;
      errReserved <= 1'b0;
      errRefCode  <= 1'b0;
      errCollide  <= 1'b0;
    end else begin
      if (strobes.capture) begin
        refreshCode <= addr[CODE_W-1:0];
        driveCode   <= addr[7:5];
      end
      errIllegal  <= strobes.illegal;
      errReserved <= strobes.reservedBits;
      errRefCode  <= strobes.badRefresh;
      errCollide  <= strobes.collide;
    end
  end

  always_comb begin
    case (refreshCode)
      3'd1:    areaQuarters = 3'd2;
      3'd2:    areaQuarters = 3'd1;
      default: areaQuarters = 3'd4;
    endcase
  end

  always_comb begin
    if (!driveCode[2]) driveEighths = 4'd8 >> driveCode[1:0];
    else begin
      case (driveCode[1:0])
        2'd0:    driveEighths = 4'd6;
        2'd1:    driveEighths = 4'd3;
        2'd2:    driveEighths = 4'd5;
        default: driveEighths = 4'd7;
      endcase
    end
  end

  a_r1_fields_captured: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> (refreshCode == $past(addr[2:0])) && (driveCode == $past(addr[7:5])));
  a_r2_hold_when_rejected: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(refreshCode) && $stable(driveCode));
  a_r7_no_reserved_stored: assert property (@(posedge clk) disable iff (!rstN)
    refreshCode <= MAX_REF_CODE);
  a_r8_area_single_bit: assert property (@(posedge clk) disable iff (!rstN)
    $countones(areaQuarters) == 1);
endmodule

// File: rtl/ext_mode_reg.sv
module ext_mode_reg
  import ext_mode_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic                 cke,
  input  logic [1:0]           bankAddr,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_BANKS-1:0] bankIdle,
  output logic [CODE_W-1:0]    refreshCode,
  output logic [CODE_W-1:0]    driveCode,
  output logic [2:0]           areaQuarters,
  output logic [3:0]           driveEighths,
  output logic                 busy,
  output logic                 errIllegal,
  output logic                 errReserved,
  output logic                 errRefCode,
  output logic                 errCollide
);
  emr_strobes_t strobes;

  emr_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .cke(cke), .bankAddr(bankAddr), .addr(addr), .bankIdle(bankIdle),
    .strobes(strobes), .busy(busy)
  );

  emr_datapath dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .addr(addr),
    .refreshCode(refreshCode), .driveCode(driveCode),
    .areaQuarters(areaQuarters), .driveEighths(driveEighths),
    .errIllegal(errIllegal), .errReserved(errReserved),
    .errRefCode(errRefCode), .errCollide(errCollide)
  );

  a_r12_deselect_quiet: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> !(errIllegal || errReserved || errRefCode || errCollide)
            && $stable(refreshCode) && $stable(driveCode));
endmodule

// File: tb/ext_mode_reg_tb_top.sv
module ext_mode_reg_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1, cke = 1'b0;
  logic [1:0]  bankAddr = '0;
  logic [13:0] addr = '0;
  logic [3:0]  bankIdle = 4'hF;
  logic [2:0]  refreshCode, driveCode, areaQuarters;
  logic [3:0]  driveEighths;
  logic        busy, errIllegal, errReserved, errRefCode, errCollide;

  int checks = 0, failures = 0, cycle = 0;

  typedef struct {
    int       due;
    string    tag;
    logic [2:0] ref3, drv3, area;
    logic [3:0] eighths;
    logic [4:0] flags;
  } exp_t;
  exp_t expQ[$];

  int         busyLeft = 0;
  logic       ckePrevM = 1'b0;
  logic [2:0] refM = '0, drvM = '0;

  always #4 clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  ext_mode_reg dut_i (.*);

  function automatic logic [2:0] areaOf(logic [2:0] c);
    return (c == 3'd1) ? 3'd2 : (c == 3'd2) ? 3'd1 : 3'd4;
  endfunction

  function automatic logic [3:0] eighthsOf(logic [2:0] c);
    case (c)
      3'd0: return 4'd8; 3'd1: return 4'd4; 3'd2: return 4'd2; 3'd3: return 4'd1;
      3'd4: return 4'd6; 3'd5: return 4'd3; 3'd6: return 4'd5; default: return 4'd7;
    endcase
  endfunction

  task automatic compare(string tag, logic [2:0] r, logic [2:0] d, logic [2:0] a,
                         logic [3:0] e, logic [4:0] f);
    logic [4:0] actF;
    actF = {busy, errIllegal, errReserved, errRefCode, errCollide};
    checks++;
    if (refreshCode !== r || driveCode !== d || areaQuarters !== a ||
        driveEighths !== e || actF !== f) begin
      failures++;
      $display("FAIL %s: act ref=%0d drv=%0d area=%0d e8=%0d flags=%b exp ref=%0d drv=%0d area=%0d e8=%0d flags=%b",
               tag, refreshCode, driveCode, areaQuarters, driveEighths, actF, r, d, a, e, f);
    end
  endtask

  // monitor: pops items whose results are due this cycle
  always @(negedge clk) begin
    while (expQ.size() > 0 && expQ[0].due == cycle) begin
      exp_t it;
      it = expQ.pop_front();
      compare(it.tag, it.ref3, it.drv3, it.area, it.eighths, it.flags);
    end
  end

  // driver: applies one cycle of command pins and pushes the expected result
  task automatic step(logic c, logic r, logic ca, logic w, logic k,
                      logic [1:0] ba, logic [13:0] ad, logic [3:0] idle, string tag);
    exp_t it;
    logic isExt, active, okPre, rsv, badR, accept, wasBusy;
    @(posedge clk); #1;
    csN = c; rasN = r; casN = ca; weN = w; cke = k; bankAddr = ba; addr = ad; bankIdle = idle;
    wasBusy = busyLeft > 0;
    active  = !c && !(r && ca && w);
    isExt   = !c && !r && !ca && !w && ba == 2'b10;
    okPre   = (&idle) && k && ckePrevM;
    rsv     = |{ad[13:8], ad[4:3]};
    badR    = ad[2:0] > 3'd2;
    accept  = isExt && !wasBusy && okPre && !rsv && !badR;
    if (accept) begin refM = ad[2:0]; drvM = ad[7:5]; busyLeft = 2; end
    else if (busyLeft > 0) busyLeft--;
    ckePrevM = k;
    it.due = cycle + 1;
    it.tag = tag;
    it.ref3 = refM; it.drv3 = drvM; it.area = areaOf(refM); it.eighths = eighthsOf(drvM);
    it.flags = {busyLeft > 0, isExt && !okPre, isExt && rsv, isExt && badR, active && wasBusy};
    expQ.push_back(it);
  endtask

  task automatic nop(string tag);
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b00, 14'h0, 4'hF, tag);
  endtask

  task automatic emrs(logic [13:0] ad, logic [3:0] idle, string tag);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b10, ad, idle, tag);
  endtask

  function automatic logic [13:0] fields(logic [2:0] d, logic [2:0] r);
    return {6'b0, d, 2'b00, r};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    compare("R11 reset state", 3'd0, 3'd0, 3'd4, 4'd8, 5'b0);
    // R3: clock enable raised in the same cycle as the command
    emrs(fields(3'd1, 3'd1), 4'hF, "R3 cke not high before");
    nop("R3 after");
    nop("warm");
    // R1 basic capture, R5 busy window
    emrs(fields(3'd3, 3'd1), 4'hF, "R1 capture");
    nop("R5 busy cycle 2");
    nop("R5 busy ends");
    // R6 back-to-back and read inside busy
    emrs(fields(3'd4, 3'd2), 4'hF, "R1 capture b");
    emrs(fields(3'd7, 3'd0), 4'hF, "R6 emrs during busy");
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'b00, 14'h0, 4'hF, "R6 read during busy");
    nop("R6 settle");
    // R8 / R9 sweep
    for (int d = 0; d < 8; d++) begin
      emrs(fields(3'(d), 3'(d % 3)), 4'hF, "R9 R8 sweep");
      nop("R5 sweep busy");
      nop("R5 sweep idle");
    end
    // R2 non-idle bank
    emrs(fields(3'd2, 3'd1), 4'b1011, "R2 bank busy");
    nop("R2 after");
    // R4 reserved bits
    emrs(fields(3'd2, 3'd1) | 14'h0400, 4'hF, "R4 addr10");
    emrs(fields(3'd2, 3'd1) | 14'h0008, 4'hF, "R4 addr3");
    emrs(fields(3'd2, 3'd1) | 14'h2000, 4'hF, "R4 addr13");
    nop("R4 after");
    // R7 reserved refresh codes
    emrs(fields(3'd5, 3'd3), 4'hF, "R7 code3");
    emrs(fields(3'd5, 3'd7), 4'hF, "R7 code7");
    nop("R7 after");
    // R12 deselected and R1 other bank value
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'b10, fields(3'd6, 3'd2), 4'hF, "R12 cs high");
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, fields(3'd6, 3'd2), 4'hF, "R1 other bank sel");
    // R10 reads and writes then rewrite
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'b01, 14'h0123, 4'hF, "R10 read");
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 14'h0040, 4'hF, "R10 write");
    emrs(fields(3'd5, 3'd2), 4'hF, "R10 rewrite");
    nop("R10 busy");
    nop("R10 idle");
    repeat (3) @(posedge clk);
    #1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    failures++;
    checks++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule